// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block places a read-only memory window in front of a serial flash device. When the window is switched on, each read request on a simple host port becomes one complete flash read sequence. The sequence sends an opcode and an address on a single line, clocks a programmed number of idle dummy bytes, and then gathers data on one, two or four lines. The result comes back to the host as 32-bit words.

Every chip select has its own setup register. That register gives the opcode, the number of address bytes, the number of dummy bytes and the data lane mode to use for reads on that device. A single switch bit turns the window on or off. While the window is off, host reads are refused with an error pulse. A read that would run past the end of the mapped window is also refused and never reaches the flash. The serial clock runs at half the system clock. Outputs change on the falling serial clock edge, and input data is sampled while the serial clock is high.

Top module: `flash_map_rd`

## Requirements
- R1: After reset every chip select is high, the serial clock is low, no output line is driven, `rd_ready` is 1, `rd_valid` and `rd_err` are 0, and the window switch is off.
- R2: Bit 0 of the register at offset 0x64 turns the window on when 1 and off when 0. A request accepted while the window is off gives a one-cycle `rd_err` in the cycle after acceptance, and no chip select is asserted.
- R3: Chip select n uses the setup register at offset 0x54+4n. Its fields are: opcode in bits 7:0, address byte count minus one in bits 9:8, dummy byte count in bits 11:10, and lane mode in bits 13:12. The register is picked by `rd_cs` and its value is captured when the request is accepted, so a later write does not change a read that is already running.
- R4: The opcode goes out first, then the low (field+1) bytes of `rd_addr`. Both are sent most significant bit first on `flash_io_out[0]`, with one bit per serial clock.
- R5: After the address, 8 serial clocks are given per dummy byte, and no line is driven during them.
- R6: Data is gathered per word with the most significant bits first, and the first byte received lands in bits 31:24. The lane mode is coded as follows. Mode 0 samples `flash_io_in[1]`. Mode 1 samples `flash_io_in[1:0]`, 2 bits per clock. Mode 3 samples `flash_io_in[3:0]`, 4 bits per clock. The unused code 2 behaves as mode 0.
- R7: A request whose `rd_len` is 0, or whose `rd_addr + 4*rd_len` is larger than the window size (4096 bytes by default), gets `rd_err` and starts no flash activity. A read that ends exactly at the window end is served.
- R8: Exactly one chip select is low, for the whole transaction. It rises on the same edge that raises the final `rd_valid`, and `rd_ready` returns one cycle after that.
- R9: The serial clock toggles every system cycle while a device is selected. The first `rd_valid` arrives 2*C cycles after the accepting edge, where C = 8 + 8*(address bytes) + 8*(dummy bytes) + 32/(lanes).
- R10: An output line is driven only during the opcode and address bits, and only while a device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 14 | Register write data |
| rd_req | input | 1 | Host read request |
| rd_cs | input | 2 | Chip select to read from |
| rd_addr | input | 24 | Byte address in the window |
| rd_len | input | 8 | Number of 32-bit words to read |
| rd_ready | output | 1 | Engine idle; a request is accepted on this cycle |
| rd_valid | output | 1 | One-cycle strobe for each returned word |
| rd_data | output | 32 | Returned word |
| rd_err | output | 1 | One-cycle refusal strobe |
| flash_sclk | output | 1 | Serial clock |
| flash_cs_n | output | 4 | Active-low chip selects |
| flash_io_out | output | 4 | Serial output lines |
| flash_io_oe | output | 4 | Output enables for the serial lines |
| flash_io_in | input | 4 | Serial input lines |

## Verification
A refusal is due one cycle after the accepting edge. The bench looks for it at the first falling clock after it raises the request. For a served read, the bench counts cycles from the accepting edge and expects the first `rd_valid` at exactly 2*C cycles. Later words follow every 2*32/lanes cycles. The chip select must be high at the sample that shows the last word, and `rd_ready` must be back one sample later. A bench-side flash model reacts to serial clock edges seen on the falling system clock. It records the opcode and address bits and drives data just after each falling serial clock. The design samples that data one full serial clock later, so no check depends on the order of processes at an edge.

// File: rtl/flmap_pkg.sv
package flmap_pkg;

  localparam int SETUP_W = 14;

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_RSV = 2'd2,
    LANE_X4  = 2'd3
  } lane_e;

  // Field order mirrors the bit positions the host writes.
  typedef struct packed {
    lane_e      lanes;
    logic [1:0] dummy;
    logic [1:0] abytes_m1;
    logic [7:0] opcode;
  } setup_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CMD   = 3'd1,
    S_DUMMY = 3'd2,
    S_DATA  = 3'd3,
    S_CLOSE = 3'd4
  } seq_e;

  localparam setup_t SETUP_RST = '{lanes: LANE_X1, dummy: 2'd0,
                                   abytes_m1: 2'd2, opcode: 8'h03};

  function automatic int lane_count(input lane_e m);
    case (m)
      LANE_X2: return 2;
      LANE_X4: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/flmap_regs.sv
module flmap_regs
  import flmap_pkg::*;
#(
  parameter int NCS        = 4,
  parameter int REG_AW     = 8,
  parameter int SWITCH_OFS = 'h64,
  parameter int SETUP_OFS  = 'h54
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [SETUP_W-1:0] wdata,
  output logic               map_en,
  output setup_t             setup_q [NCS]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_en <= 1'b0;
    end else if (we && addr == REG_AW'(SWITCH_OFS)) begin
      map_en <= wdata[0];
    end
  end

  for (genvar n = 0; n < NCS; n++) begin : g_setup
    localparam logic [REG_AW-1:0] OFS = REG_AW'(SETUP_OFS + 4 * n);
    always_ff @(posedge clk) begin
      if (rst) begin
        setup_q[n] <= SETUP_RST;
      end else if (we && addr == OFS) begin
        setup_q[n] <= setup_t'(wdata);
      end
    end
  end

endmodule

// File: rtl/flmap_ctrl.sv
module flmap_ctrl
  import flmap_pkg::*;
#(
  parameter int NCS       = 4,
  parameter int CS_W      = (NCS > 1) ? $clog2(NCS) : 1,
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 32,
  parameter int WIN_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              map_en,
  input  setup_t            setup [NCS],
  output logic              ready,
  output logic              valid,
  output logic              err,
  output logic              sck,
  output logic [NCS-1:0]    cs_n,
  output logic              oe0,
  output logic              dp_load,
  output logic [7:0]        dp_op,
  output logic [1:0]        dp_abm1,
  output logic              dp_tx_shift,
  output logic              dp_rx_shift,
  output logic              dp_word_end,
  output lane_e             dp_lanes
);

  localparam int WB    = DATA_W / 8;
  localparam int END_W = ADDR_W + LEN_W + 4;
  localparam int CNT_W = $clog2(((DATA_W > 40) ? DATA_W : 40) + 1);

  seq_e              st;
  setup_t            cur;
  setup_t            sel;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  words;
  logic [END_W-1:0]  end_addr;
  logic              accept, cs_ok, win_ok, start_ok, last_bit;

  function automatic logic [CNT_W-1:0] clocks_per_word(input lane_e m);
    return CNT_W'(DATA_W / lane_count(m));
  endfunction

  assign sel      = setup[req_cs];
  assign cs_ok    = int'(req_cs) < NCS;
  assign end_addr = END_W'(req_addr) + END_W'(req_len) * END_W'(WB);
  assign win_ok   = (req_len != '0) && (end_addr <= END_W'(WIN_BYTES));
  assign accept   = (st == S_IDLE) && req;
  assign start_ok = accept && map_en && cs_ok && win_ok;
  assign last_bit = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cur   <= SETUP_RST;
      cnt   <= '0;
      words <= '0;
      sck   <= 1'b0;
      cs_n  <= '1;
      oe0   <= 1'b0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            if (start_ok) begin
              st    <= S_CMD;
              cur   <= sel;
              cs_n  <= ~(NCS'(1) << req_cs);
              oe0   <= 1'b1;
              cnt   <= CNT_W'(16 + 8 * int'(sel.abytes_m1));
              words <= req_len;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_CMD: begin
          sck <= ~sck;
          if (sck) begin
            if (last_bit) begin
              oe0 <= 1'b0;
              if (cur.dummy != 2'd0) begin
                st  <= S_DUMMY;
                cnt <= CNT_W'(8 * int'(cur.dummy));
              end else begin
                st  <= S_DATA;
                cnt <= clocks_per_word(cur.lanes);
              end
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        S_DUMMY: begin
          sck <= ~sck;
          if (sck) begin
            if (last_bit) begin
              st  <= S_DATA;
              cnt <= clocks_per_word(cur.lanes);
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        S_DATA: begin
          sck <= ~sck;
          if (sck) begin
            if (last_bit) begin
              valid <= 1'b1;
              cnt   <= clocks_per_word(cur.lanes);
              if (words == LEN_W'(1)) begin
                st   <= S_CLOSE;
                cs_n <= '1;
              end else begin
                words <= words - LEN_W'(1);
              end
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        S_CLOSE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready       = (st == S_IDLE);
  assign dp_load     = start_ok;
  assign dp_op       = sel.opcode;
  assign dp_abm1     = sel.abytes_m1;
  assign dp_tx_shift = (st == S_CMD) && sck;
  assign dp_rx_shift = (st == S_DATA) && sck;
  assign dp_word_end = dp_rx_shift && last_bit;
  assign dp_lanes    = cur.lanes;

endmodule

// File: rtl/flmap_dpath.sv
module flmap_dpath
  import flmap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [7:0]        op,
  input  logic [1:0]        abm1,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tx_shift,
  input  logic              rx_shift,
  input  logic              word_end,
  input  lane_e             lanes,
  input  logic [3:0]        io_in,
  output logic              tx_bit,
  output logic [DATA_W-1:0] word
);

  localparam int TX_W = 40;

  logic [TX_W-1:0]   tx_sr;
  logic [DATA_W-1:0] rx_sr, rx_nxt;
  logic [31:0]       addr_al;

  // Left-align the address so its top sent byte sits just below the opcode.
  assign addr_al = 32'(addr) << (8 * (3 - int'(abm1)));

  always_comb begin
    case (lanes)
      LANE_X2: rx_nxt = {rx_sr[DATA_W-3:0], io_in[1:0]};
      LANE_X4: rx_nxt = {rx_sr[DATA_W-5:0], io_in};
      default: rx_nxt = {rx_sr[DATA_W-2:0], io_in[1]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
      word  <= '0;
    end else begin
      if (load) begin
        tx_sr <= {op, addr_al};
      end else if (tx_shift) begin
        tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
      end
      if (rx_shift) begin
        rx_sr <= rx_nxt;
      end
      if (word_end) begin
        word <= rx_nxt;
      end
    end
  end

  assign tx_bit = tx_sr[TX_W-1];

endmodule

// File: rtl/flash_map_rd.sv
module flash_map_rd
  import flmap_pkg::*;
#(
  parameter int NCS       = 4,
  parameter int CS_W      = (NCS > 1) ? $clog2(NCS) : 1,
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 8,
  parameter int WIN_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [13:0]       reg_wdata,
  input  logic              rd_req,
  input  logic [CS_W-1:0]   rd_cs,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  output logic              flash_sclk,
  output logic [NCS-1:0]    flash_cs_n,
  output logic [3:0]        flash_io_out,
  output logic [3:0]        flash_io_oe,
  input  logic [3:0]        flash_io_in
);

  logic       map_en;
  setup_t     setup_q [NCS];
  logic       oe0, tx_bit;
  logic       dp_load, dp_tx_shift, dp_rx_shift, dp_word_end;
  logic [7:0] dp_op;
  logic [1:0] dp_abm1;
  lane_e      dp_lanes;

  flmap_regs #(
    .NCS(NCS), .REG_AW(REG_AW)
  ) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .map_en(map_en), .setup_q(setup_q)
  );

  flmap_ctrl #(
    .NCS(NCS), .CS_W(CS_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .DATA_W(DATA_W), .WIN_BYTES(WIN_BYTES)
  ) i_ctrl (
    .clk(clk), .rst(rst), .req(rd_req), .req_cs(rd_cs), .req_addr(rd_addr),
    .req_len(rd_len), .map_en(map_en), .setup(setup_q),
    .ready(rd_ready), .valid(rd_valid), .err(rd_err), .sck(flash_sclk),
    .cs_n(flash_cs_n), .oe0(oe0), .dp_load(dp_load), .dp_op(dp_op),
    .dp_abm1(dp_abm1), .dp_tx_shift(dp_tx_shift), .dp_rx_shift(dp_rx_shift),
    .dp_word_end(dp_word_end), .dp_lanes(dp_lanes)
  );

  flmap_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dpath (
    .clk(clk), .rst(rst), .load(dp_load), .op(dp_op), .abm1(dp_abm1),
    .addr(rd_addr), .tx_shift(dp_tx_shift), .rx_shift(dp_rx_shift),
    .word_end(dp_word_end), .lanes(dp_lanes), .io_in(flash_io_in),
    .tx_bit(tx_bit), .word(rd_data)
  );

  assign flash_io_out = {3'b000, tx_bit};
  assign flash_io_oe  = {3'b000, oe0};

endmodule

// File: rtl/flmap_chk.sv
module flmap_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_ready,
  input logic           rd_valid,
  input logic           rd_err,
  input logic           flash_sclk,
  input logic [NCS-1:0] flash_cs_n,
  input logic [3:0]     flash_io_oe
);

  a_r8_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~flash_cs_n));

  a_r8_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> &flash_cs_n);

  a_r2_refusal_no_select: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> &flash_cs_n);

  a_r7_refusal_not_valid: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !rd_valid);

  a_r10_drive_only_selected: assert property (@(posedge clk) disable iff (rst)
    (|flash_io_oe) |-> !(&flash_cs_n));

  a_r9_sclk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    (&flash_cs_n) |-> !flash_sclk);

  a_r9_sclk_half_rate: assert property (@(posedge clk) disable iff (rst)
    flash_sclk |=> !flash_sclk);

  a_r6_word_from_transaction: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!(&flash_cs_n)));

endmodule

bind flash_map_rd flmap_chk #(.NCS(NCS)) i_flmap_chk (
  .clk(clk), .rst(rst), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .rd_err(rd_err), .flash_sclk(flash_sclk), .flash_cs_n(flash_cs_n),
  .flash_io_oe(flash_io_oe)
);

// File: tb/test_flash_map_rd.sv
module test_flash_map_rd;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [13:0] reg_wdata = '0;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_cs = '0;
  logic [23:0] rd_addr = '0;
  logic [7:0]  rd_len = '0;
  logic        rd_ready, rd_valid, rd_err, flash_sclk;
  logic [31:0] rd_data;
  logic [3:0]  flash_cs_n, flash_io_out, flash_io_oe;
  logic [3:0]  flash_io_in = '0;

  always #5 clk = ~clk;

  flash_map_rd i_flash_map_rd (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_req(rd_req), .rd_cs(rd_cs), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .flash_sclk(flash_sclk),
    .flash_cs_n(flash_cs_n), .flash_io_out(flash_io_out),
    .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in)
  );

  int total = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hA5;
  endfunction

  // Flash model: sees serial clock edges on the falling system clock.
  int          m_L = 1, m_nab = 3, m_nd = 0;
  int          rises = 0, cs_seen = -1, oe_dummy_bad = 0;
  logic [7:0]  op_cap = '0;
  logic [31:0] a_cap = '0;
  logic        prev_sclk = 1'b0, prev_all = 1'b1;

  always @(negedge clk) begin
    int s_len;
    s_len = 8 + 8 * m_nab + 8 * m_nd;
    if (prev_all && !(&flash_cs_n)) begin
      rises  = 0;
      op_cap = '0;
      a_cap  = '0;
      for (int i = 0; i < 4; i++) if (!flash_cs_n[i]) cs_seen = i;
    end
    if (!(&flash_cs_n)) begin
      if (flash_sclk && !prev_sclk) begin
        if (rises < 8) op_cap = {op_cap[6:0], flash_io_out[0]};
        else if (rises < 8 + 8 * m_nab) a_cap = {a_cap[30:0], flash_io_out[0]};
        else if (rises < s_len && flash_io_oe != 4'd0) oe_dummy_bad++;
        rises++;
      end else if (!flash_sclk && prev_sclk && rises >= s_len) begin
        int bitoff, pos;
        logic [7:0] b;
        logic [3:0] v;
        bitoff = (rises - s_len) * m_L;
        b = fbyte(a_cap + 32'(bitoff / 8));
        pos = bitoff % 8;
        v = 4'((b >> (8 - pos - m_L)) & ((1 << m_L) - 1));
        if (m_L == 1) flash_io_in = {2'b00, v[0], 1'b0};
        else flash_io_in = v;
      end
    end
    prev_sclk = flash_sclk;
    prev_all  = &flash_cs_n;
  end

  logic [31:0] got_w [16];
  int   first_cyc, nwords, err_cyc, any_sel, last_hi, ready_at_end;

  task automatic write_reg(input logic [7:0] a, input logic [13:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_read(input int cs, input logic [23:0] a, input int len);
    int cyc;
    @(negedge clk);
    rd_req = 1'b1; rd_cs = 2'(cs); rd_addr = a; rd_len = 8'(len);
    @(negedge clk);
    rd_req = 1'b0;
    cyc = 0; first_cyc = -1; nwords = 0; err_cyc = -1; any_sel = 0; last_hi = 0;
    ready_at_end = 1;
    while (cyc < 4000) begin
      if (rd_err && err_cyc < 0) err_cyc = cyc;
      if (!(&flash_cs_n)) any_sel = 1;
      if (rd_valid) begin
        if (first_cyc < 0) first_cyc = cyc;
        if (nwords < 16) got_w[nwords] = rd_data;
        nwords++;
        if (nwords == len) begin
          last_hi = &flash_cs_n;
          ready_at_end = rd_ready;
        end
      end
      if (err_cyc >= 0 && cyc >= 8) break;
      if (len > 0 && nwords == len && (&flash_cs_n)) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  // {cs, setup{lanes,dummy,abm1,opcode}, addr, len}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 2'd2, 8'h03, 24'h000100, 8'd2},
    {2'd1, 2'd1, 2'd1, 2'd2, 8'h3B, 24'h000204, 8'd1},
    {2'd2, 2'd3, 2'd2, 2'd3, 8'h6B, 24'h000ABC, 8'd3},
    {2'd3, 2'd2, 2'd0, 2'd0, 8'h0B, 24'h0000F0, 8'd2},
    {2'd0, 2'd3, 2'd3, 2'd1, 8'hEB, 24'h000FF0, 8'd4},
    {2'd1, 2'd0, 2'd1, 2'd2, 8'h0B, 24'h000003, 8'd1}
  };

  task automatic set_model(input logic [13:0] s);
    m_L   = (s[13:12] == 2'd1) ? 2 : (s[13:12] == 2'd3) ? 4 : 1;
    m_nab = int'(s[9:8]) + 1;
    m_nd  = int'(s[11:10]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(flash_cs_n == 4'hF, "R1 cs_n", 64'(flash_cs_n), 64'hF);
    chk(flash_sclk == 1'b0, "R1 sclk", 64'(flash_sclk), 64'h0);
    chk(flash_io_oe == 4'h0, "R1 oe", 64'(flash_io_oe), 64'h0);
    chk(rd_ready == 1'b1, "R1 ready", 64'(rd_ready), 64'h1);
    chk(rd_valid == 1'b0 && rd_err == 1'b0, "R1 strobes",
        64'({rd_valid, rd_err}), 64'h0);

    // R2: window off at reset, read refused
    do_read(0, 24'h000010, 1);
    chk(err_cyc == 0, "R2 refused while off", 64'(err_cyc), 64'h0);
    chk(any_sel == 0 && nwords == 0, "R2 no select while off",
        64'({any_sel[0], nwords[7:0]}), 64'h0);

    write_reg(8'h64, 14'h0001);

    for (int v = 0; v < NV; v++) begin
      int cs, len, c_exp;
      logic [13:0] s;
      logic [23:0] a;
      logic [31:0] amask;
      cs  = int'(VEC[v][47:46]);
      s   = VEC[v][45:32];
      a   = VEC[v][31:8];
      len = int'(VEC[v][7:0]);
      write_reg(8'(8'h54 + 4 * cs), s);
      set_model(s);
      oe_dummy_bad = 0;
      do_read(cs, a, len);
      amask = (m_nab == 4) ? 32'hFFFFFFFF : ((32'h1 << (8 * m_nab)) - 1);
      c_exp = 8 + 8 * m_nab + 8 * m_nd + 32 / m_L;
      chk(err_cyc < 0, "R7 in-window read served", 64'(err_cyc), 64'hFFFFFFFF);
      chk(nwords == len, "R8 word count", 64'(nwords), 64'(len));
      chk(op_cap == s[7:0], "R4 opcode", 64'(op_cap), 64'(s[7:0]));
      chk(a_cap == (32'(a) & amask), "R4 address", 64'(a_cap),
          64'(32'(a) & amask));
      chk(cs_seen == cs, "R3 chip select", 64'(cs_seen), 64'(cs));
      chk(first_cyc == 2 * c_exp, "R9 first word timing", 64'(first_cyc),
          64'(2 * c_exp));
      chk(oe_dummy_bad == 0, "R5 dummy undriven", 64'(oe_dummy_bad), 64'h0);
      chk(last_hi == 1 && ready_at_end == 0, "R8 cs rises with last word",
          64'({last_hi[0], ready_at_end[0]}), 64'h2);
      for (int w = 0; w < len && w < 16; w++) begin
        logic [31:0] b0, exp_w;
        b0 = (32'(a) & amask) + 32'(4 * w);
        exp_w = {fbyte(b0), fbyte(b0 + 1), fbyte(b0 + 2), fbyte(b0 + 3)};
        chk(got_w[w] == exp_w, "R6 data word", 64'(got_w[w]), 64'(exp_w));
      end
      @(negedge clk);
      chk(rd_ready == 1'b1, "R8 ready after close", 64'(rd_ready), 64'h1);
    end

    // R7: past the window end
    do_read(0, 24'h000FFD, 1);
    chk(err_cyc == 0, "R7 overrun refused", 64'(err_cyc), 64'h0);
    chk(any_sel == 0 && nwords == 0, "R7 overrun no activity",
        64'({any_sel[0], nwords[7:0]}), 64'h0);
    // R7: zero length
    do_read(1, 24'h000000, 0);
    chk(err_cyc == 0, "R7 zero length refused", 64'(err_cyc), 64'h0);
    chk(any_sel == 0, "R7 zero length no select", 64'(any_sel), 64'h0);

    // R3: setup captured at acceptance, write mid-transaction has no effect
    write_reg(8'h54, 14'h0203);
    set_model(14'h0203);
    fork
      do_read(0, 24'h000040, 2);
      begin
        repeat (6) @(negedge clk);
        write_reg(8'h54, 14'h31AA);
      end
    join
    chk(op_cap == 8'h03, "R3 opcode latched", 64'(op_cap), 64'h03);
    chk(nwords == 2 && got_w[0] == {fbyte(32'h40), fbyte(32'h41),
        fbyte(32'h42), fbyte(32'h43)}, "R3 lanes latched", 64'(got_w[0]),
        64'({fbyte(32'h40), fbyte(32'h41), fbyte(32'h42), fbyte(32'h43)}));

    // R2: switch back off
    write_reg(8'h64, 14'h0000);
    do_read(2, 24'h000000, 1);
    chk(err_cyc == 0 && any_sel == 0, "R2 refused after switch off",
        64'({err_cyc[7:0], any_sel[0]}), 64'h0);
    // R10: lines released afterwards
    chk(flash_io_oe == 4'h0, "R10 lines idle", 64'(flash_io_oe), 64'h0);

    summary();
  end

endmodule